// File: doc/BRIEF.md
# UART Channel Control Unit

This block is the control side of one channel of a multi-channel UART. A byte-wide register bus reaches it through a small address window. Writes to its command register switch the receiver and transmitter on or off and issue one-shot commands: resets for either direction, status clears and break control. The same register can also reposition the mode-register pointer.

Three mode registers share a single address. An internal pointer picks which one a mode access reaches, and it moves forward by itself on every access. The block holds the character format and the FIFO options taken from those registers and presents them as decoded fields.

The serial shifters and FIFOs live in a separate datapath. They appear here only as level flags, which are folded into the status byte, and as one-cycle pulses, which tell the datapath to reset, clear, load or pop.

Top module: `uart_chan_ctrl`

## Requirements
- R1: The channel's window starts at CHAN_ID*8 and holds four registers: offset 0 (mode), offset 1 (status read / clock-select write), offset 2 (command) and offset 3 (receive read / transmit write). An access to any address outside those four changes no state, produces no pulse and reads as 0.
- R2: After reset both directions are disabled, break is off, no pulse is active, all mode registers are 0 and the mode pointer selects MR1.
- R3: A command write uses bit 0 to enable the receiver, bit 1 to disable it, bit 2 to enable the transmitter and bit 3 to disable it. When enable and disable are both set for one direction, disable wins. When neither is set, that direction keeps its state.
- R4: Command code (bits 7:4) 2 gives a one-cycle rx_reset_p pulse and code 3 gives a one-cycle tx_reset_p pulse. Each clears its own direction's enable, and this overrides any enable bit in the same write.
- R5: Code 4 gives a one-cycle err_clear_p pulse and code 5 gives a one-cycle brk_chg_clear_p pulse. At most one command pulse is active in any cycle.
- R6: Code 6 sets break_on and code 7 clears it. No other code changes break_on.
- R7: Every read or write at offset 0 reaches the register the pointer selects. The pointer then advances MR0 to MR1 to MR2 and stays at MR2. Code 1 moves it to MR1 and code 0xB moves it to MR0. No other code moves it.
- R8: MR1 bits 1:0 give char_bits = 5 + code (5 to 8). parity_en is 1 only when MR1 bits 4:3 are 00, and then parity_odd equals MR1 bit 2 (0 even, 1 odd). Code 4 (binary 100) means no parity.
- R9: stop_two is MR2 bit 3, so value 7 selects one stop bit and value 0xF selects two.
- R10: fifo_deep follows MR0 bit 3 and tx_half_level follows MR0 bit 4.
- R11: A status read returns {rx_break, frame_err, parity_err, overrun, tx_empty, tx_ready, fifo_full, rx_ready} from bit 7 down to bit 0. A write at offset 1 loads clk_sel.
- R12: A write at offset 3 gives a one-cycle tx_load_p and latches tx_byte. A read at offset 3 returns rx_byte and gives a one-cycle rx_pop_p in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| st_rx_ready | input | 1 | Receive data available |
| st_fifo_full | input | 1 | Receive FIFO full |
| st_tx_ready | input | 1 | Transmit holding space free |
| st_tx_empty | input | 1 | Transmitter fully idle |
| st_overrun | input | 1 | Receive overrun seen |
| st_parity_err | input | 1 | Parity error on current character |
| st_frame_err | input | 1 | Framing error on current character |
| st_rx_break | input | 1 | Break received |
| rx_byte | input | DATA_W | Character at the head of the receive FIFO |
| rx_enable | output | 1 | Receiver enabled |
| tx_enable | output | 1 | Transmitter enabled |
| rx_reset_p | output | 1 | Receiver reset pulse |
| tx_reset_p | output | 1 | Transmitter reset pulse |
| err_clear_p | output | 1 | Error-status clear pulse |
| brk_chg_clear_p | output | 1 | Break-change flag clear pulse |
| break_on | output | 1 | Transmit line held in break |
| tx_load_p | output | 1 | Transmit character load pulse |
| tx_byte | output | DATA_W | Last character written for transmit |
| rx_pop_p | output | 1 | Receive FIFO pop pulse |
| clk_sel | output | DATA_W | Clock-select byte |
| char_bits | output | 4 | Data bits per character (5 to 8) |
| parity_en | output | 1 | Parity generated and checked |
| parity_odd | output | 1 | Odd parity when enabled |
| stop_two | output | 1 | Two stop bits |
| fifo_deep | output | 1 | Deep FIFO mode |
| tx_half_level | output | 1 | Transmit-ready at half-level threshold |

## Verification
The properties assume a bus that never raises the read and write strobes in the same cycle, holds the strobes low during reset, and makes at most one access per cycle. The bench keeps to these rules: every access is one strobe for one cycle, followed by an idle cycle before the next access. Status flags and rx_byte are taken as levels that settle before a read, so the bench changes them only while no read is under way. The sweeps cover every command byte from two starting enable states, every address in the bus space, every status pattern and every MR1/MR2 value. In each case the expected fields are computed arithmetically.

// File: rtl/uart_cc_pkg.sv
package uart_cc_pkg;
   typedef enum logic [1:0] {
      MP_MR0 = 2'd0,
      MP_MR1 = 2'd1,
      MP_MR2 = 2'd2
   } mptr_e;

   localparam logic [1:0] OFS_MODE = 2'd0;
   localparam logic [1:0] OFS_STAT = 2'd1;
   localparam logic [1:0] OFS_CMD  = 2'd2;
   localparam logic [1:0] OFS_DATA = 2'd3;

   localparam logic [3:0] CC_PTR_MR1 = 4'h1;
   localparam logic [3:0] CC_RX_RST  = 4'h2;
   localparam logic [3:0] CC_TX_RST  = 4'h3;
   localparam logic [3:0] CC_ERR_CLR = 4'h4;
   localparam logic [3:0] CC_BRK_CLR = 4'h5;
   localparam logic [3:0] CC_BRK_ON  = 4'h6;
   localparam logic [3:0] CC_BRK_OFF = 4'h7;
   localparam logic [3:0] CC_PTR_MR0 = 4'hB;

   typedef struct packed {
      logic [3:0] code;
      logic       tx_off;
      logic       tx_on;
      logic       rx_off;
      logic       rx_on;
   } cmd_word_t;
endpackage

// File: rtl/uart_cc_decode.sv
module uart_cc_decode #(
   parameter int ADDR_W  = 4,
   parameter int CHAN_ID = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output logic              mode_acc,
   output logic              mode_wr,
   output logic              csel_wr,
   output logic              cmd_wr,
   output logic              thr_wr,
   output logic              rhr_rd,
   output logic              rd_hit,
   output logic [1:0]        rd_sel
);
   import uart_cc_pkg::*;

   localparam int WIN_W = ADDR_W - 3;
   localparam logic [WIN_W-1:0] WIN = WIN_W'(CHAN_ID);

   logic       hit;
   logic [1:0] ofs;

   assign hit = (addr[ADDR_W-1:3] == WIN) && !addr[2];
   assign ofs = addr[1:0];

   assign mode_acc = hit && (wr || rd) && (ofs == OFS_MODE);
   assign mode_wr  = hit && wr && (ofs == OFS_MODE);
   assign csel_wr  = hit && wr && (ofs == OFS_STAT);
   assign cmd_wr   = hit && wr && (ofs == OFS_CMD);
   assign thr_wr   = hit && wr && (ofs == OFS_DATA);
   assign rhr_rd   = hit && rd && (ofs == OFS_DATA);
   assign rd_hit   = hit && rd;
   assign rd_sel   = ofs;
endmodule

// File: rtl/uart_cc_cmd.sv
module uart_cc_cmd #(
   parameter int  DATA_W  = 8,
   parameter bit  HAS_MR0 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              rx_en,
   output logic              tx_en,
   output logic              rx_rst_p,
   output logic              tx_rst_p,
   output logic              err_clr_p,
   output logic              brk_clr_p,
   output logic              brk_on,
   output logic              go_mr1,
   output logic              go_mr0
);
   import uart_cc_pkg::*;

   cmd_word_t c;
   assign c = cmd_word_t'(wdata[7:0]);

   assign go_mr1 = cmd_wr && (c.code == CC_PTR_MR1);

   generate
      if (HAS_MR0) begin : g_mr0_cmd
         assign go_mr0 = cmd_wr && (c.code == CC_PTR_MR0);
      end else begin : g_no_mr0_cmd
         assign go_mr0 = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en     <= 1'b0;
         tx_en     <= 1'b0;
         rx_rst_p  <= 1'b0;
         tx_rst_p  <= 1'b0;
         err_clr_p <= 1'b0;
         brk_clr_p <= 1'b0;
         brk_on    <= 1'b0;
      end else begin
         rx_rst_p  <= 1'b0;
         tx_rst_p  <= 1'b0;
         err_clr_p <= 1'b0;
         brk_clr_p <= 1'b0;
         if (cmd_wr) begin
            if (c.rx_off)     rx_en <= 1'b0;
            else if (c.rx_on) rx_en <= 1'b1;
            if (c.tx_off)     tx_en <= 1'b0;
            else if (c.tx_on) tx_en <= 1'b1;
            case (c.code)
               CC_RX_RST: begin
                  rx_rst_p <= 1'b1;
                  rx_en    <= 1'b0;
               end
               CC_TX_RST: begin
                  tx_rst_p <= 1'b1;
                  tx_en    <= 1'b0;
               end
               CC_ERR_CLR: err_clr_p <= 1'b1;
               CC_BRK_CLR: brk_clr_p <= 1'b1;
               CC_BRK_ON:  brk_on    <= 1'b1;
               CC_BRK_OFF: brk_on    <= 1'b0;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_cc_mode.sv
module uart_cc_mode #(
   parameter int DATA_W  = 8,
   parameter bit HAS_MR0 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_acc,
   input  logic              mode_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              go_mr1,
   input  logic              go_mr0,
   output logic [DATA_W-1:0] mode_rdata,
   output logic              fifo_deep,
   output logic              tx_half,
   output logic [4:0]        fmt,
   output logic [3:0]        stop_code
);
   import uart_cc_pkg::*;

   mptr_e             ptr;
   logic [DATA_W-1:0] mr0;
   logic [DATA_W-1:0] mr1;
   logic [DATA_W-1:0] mr2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= MP_MR1;
      end else if (go_mr0) begin
         ptr <= MP_MR0;
      end else if (go_mr1) begin
         ptr <= MP_MR1;
      end else if (mode_acc) begin
         case (ptr)
            MP_MR0:  ptr <= MP_MR1;
            default: ptr <= MP_MR2;
         endcase
      end
   end

   generate
      if (HAS_MR0) begin : g_mr0
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mr0 <= '0;
            else if (mode_wr && ptr == MP_MR0)   mr0 <= wdata;
         end
      end else begin : g_no_mr0
         assign mr0 = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mr1 <= '0;
         mr2 <= '0;
      end else if (mode_wr) begin
         if (ptr == MP_MR1) mr1 <= wdata;
         if (ptr == MP_MR2) mr2 <= wdata;
      end
   end

   always_comb begin
      case (ptr)
         MP_MR0:  mode_rdata = mr0;
         MP_MR1:  mode_rdata = mr1;
         default: mode_rdata = mr2;
      endcase
   end

   assign fifo_deep = mr0[3];
   assign tx_half   = mr0[4];
   assign fmt       = mr1[4:0];
   assign stop_code = mr2[3:0];
endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl #(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int CHAN_ID = 0,
   parameter bit HAS_MR0 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              st_rx_ready,
   input  logic              st_fifo_full,
   input  logic              st_tx_ready,
   input  logic              st_tx_empty,
   input  logic              st_overrun,
   input  logic              st_parity_err,
   input  logic              st_frame_err,
   input  logic              st_rx_break,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              rx_enable,
   output logic              tx_enable,
   output logic              rx_reset_p,
   output logic              tx_reset_p,
   output logic              err_clear_p,
   output logic              brk_chg_clear_p,
   output logic              break_on,
   output logic              tx_load_p,
   output logic [DATA_W-1:0] tx_byte,
   output logic              rx_pop_p,
   output logic [DATA_W-1:0] clk_sel,
   output logic [3:0]        char_bits,
   output logic              parity_en,
   output logic              parity_odd,
   output logic              stop_two,
   output logic              fifo_deep,
   output logic              tx_half_level
);
   import uart_cc_pkg::*;

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("uart_chan_ctrl: DATA_W must be 8");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("uart_chan_ctrl: ADDR_W must be at least 4");
      end
      if (CHAN_ID < 0 || CHAN_ID >= (1 << (ADDR_W - 3))) begin : g_bad_chan
         $error("uart_chan_ctrl: CHAN_ID outside the address space");
      end
   endgenerate

   logic              mode_acc, mode_wr, csel_wr, cmd_wr, thr_wr, rhr_rd, rd_hit;
   logic [1:0]        rd_sel;
   logic              go_mr1, go_mr0;
   logic [DATA_W-1:0] mode_rdata;
   logic [4:0]        fmt;
   logic [3:0]        stop_code;
   logic [DATA_W-1:0] status;

   uart_cc_decode #(.ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID)) u_dec (
      .addr     (bus_addr),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .mode_acc (mode_acc),
      .mode_wr  (mode_wr),
      .csel_wr  (csel_wr),
      .cmd_wr   (cmd_wr),
      .thr_wr   (thr_wr),
      .rhr_rd   (rhr_rd),
      .rd_hit   (rd_hit),
      .rd_sel   (rd_sel)
   );

   uart_cc_cmd #(.DATA_W(DATA_W), .HAS_MR0(HAS_MR0)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .wdata     (bus_wdata),
      .rx_en     (rx_enable),
      .tx_en     (tx_enable),
      .rx_rst_p  (rx_reset_p),
      .tx_rst_p  (tx_reset_p),
      .err_clr_p (err_clear_p),
      .brk_clr_p (brk_chg_clear_p),
      .brk_on    (break_on),
      .go_mr1    (go_mr1),
      .go_mr0    (go_mr0)
   );

   uart_cc_mode #(.DATA_W(DATA_W), .HAS_MR0(HAS_MR0)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_acc   (mode_acc),
      .mode_wr    (mode_wr),
      .wdata      (bus_wdata),
      .go_mr1     (go_mr1),
      .go_mr0     (go_mr0),
      .mode_rdata (mode_rdata),
      .fifo_deep  (fifo_deep),
      .tx_half    (tx_half_level),
      .fmt        (fmt),
      .stop_code  (stop_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_load_p <= 1'b0;
         rx_pop_p  <= 1'b0;
         tx_byte   <= '0;
         clk_sel   <= '0;
      end else begin
         tx_load_p <= thr_wr;
         rx_pop_p  <= rhr_rd;
         if (thr_wr)  tx_byte <= bus_wdata;
         if (csel_wr) clk_sel <= bus_wdata;
      end
   end

   assign status = {st_rx_break, st_frame_err, st_parity_err, st_overrun,
                    st_tx_empty, st_tx_ready, st_fifo_full, st_rx_ready};

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         case (rd_sel)
            OFS_MODE: bus_rdata = mode_rdata;
            OFS_STAT: bus_rdata = status;
            OFS_DATA: bus_rdata = rx_byte;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign char_bits  = 4'd5 + {2'b00, fmt[1:0]};
   assign parity_en  = (fmt[4:3] == 2'b00);
   assign parity_odd = parity_en && fmt[2];
   assign stop_two   = stop_code[3];
endmodule

// File: rtl/uart_cc_chk.sv
module uart_cc_chk #(
   parameter int ADDR_W  = 4,
   parameter int CHAN_ID = 0,
   parameter int DATA_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              rx_enable,
   input logic              tx_enable,
   input logic              rx_reset_p,
   input logic              tx_reset_p,
   input logic              err_clear_p,
   input logic              brk_chg_clear_p,
   input logic              break_on,
   input logic              tx_load_p,
   input logic [DATA_W-1:0] tx_byte,
   input logic              rx_pop_p,
   input logic [DATA_W-1:0] clk_sel,
   input logic [3:0]        char_bits
);
   localparam int WIN_W = ADDR_W - 3;
   localparam logic [WIN_W-1:0] WIN = WIN_W'(CHAN_ID);

   logic in_win;
   logic at_stat, at_cmd, at_data;
   assign in_win  = (bus_addr[ADDR_W-1:3] == WIN) && !bus_addr[2];
   assign at_stat = in_win && bus_addr[1:0] == 2'd1;
   assign at_cmd  = in_win && bus_addr[1:0] == 2'd2;
   assign at_data = in_win && bus_addr[1:0] == 2'd3;

   a_r1_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   a_r3_rx_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_cmd && bus_wdata[1]) |=> !rx_enable);

   a_r3_tx_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_cmd && bus_wdata[3]) |=> !tx_enable);

   a_r4_rx_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset_p |-> !rx_enable);

   a_r4_tx_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tx_reset_p |-> !tx_enable);

   a_r5_one_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_reset_p, tx_reset_p, err_clear_p, brk_chg_clear_p}));

   a_r6_brk_start: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_cmd && bus_wdata[7:4] == 4'h6) |=> break_on);

   a_r6_brk_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_cmd && bus_wdata[7:4] == 4'h7) |=> !break_on);

   a_r8_char_bits_range: assert property (@(posedge clk) disable iff (!rst_n)
      char_bits >= 4'd5 && char_bits <= 4'd8);

   a_r11_clk_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && at_stat) |=> $stable(clk_sel));

   a_r12_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_data) |=> (tx_load_p && tx_byte == $past(bus_wdata)));

   a_r12_rx_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && at_data) |=> rx_pop_p);
endmodule

bind uart_chan_ctrl uart_cc_chk #(
   .ADDR_W  (ADDR_W),
   .CHAN_ID (CHAN_ID),
   .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/sim_uart_chan_ctrl.sv
`timescale 1ns/1ps
module sim_uart_chan_ctrl;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int A_MODE = 8;
   localparam int A_STAT = 9;
   localparam int A_CMD  = 10;
   localparam int A_DATA = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [7:0]    st_vec = '0;
   logic [DW-1:0] rx_byte = '0;
   logic rx_enable, tx_enable, rx_reset_p, tx_reset_p, err_clear_p, brk_chg_clear_p;
   logic break_on, tx_load_p, rx_pop_p;
   logic [DW-1:0] tx_byte, clk_sel;
   logic [3:0] char_bits;
   logic parity_en, parity_odd, stop_two, fifo_deep, tx_half_level;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   uart_chan_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CHAN_ID(1)) u0 (
      .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
      .st_rx_ready(st_vec[0]), .st_fifo_full(st_vec[1]), .st_tx_ready(st_vec[2]),
      .st_tx_empty(st_vec[3]), .st_overrun(st_vec[4]), .st_parity_err(st_vec[5]),
      .st_frame_err(st_vec[6]), .st_rx_break(st_vec[7]), .rx_byte,
      .rx_enable, .tx_enable, .rx_reset_p, .tx_reset_p, .err_clear_p, .brk_chg_clear_p,
      .break_on, .tx_load_p, .tx_byte, .rx_pop_p, .clk_sel, .char_bits,
      .parity_en, .parity_odd, .stop_two, .fifo_deep, .tx_half_level
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = DW'(d); bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int a, output int d);
      @(negedge clk);
      bus_addr = AW'(a); bus_rd = 1'b1;
      #1 d = int'(bus_rdata);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      int d;
      int prx, ptx, erx, etx, ebrk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state
      chk("R2", "rx_enable", rx_enable, 0);
      chk("R2", "tx_enable", tx_enable, 0);
      chk("R2", "break_on", break_on, 0);
      chk("R2", "pulses", {rx_reset_p, tx_reset_p, err_clear_p, brk_chg_clear_p, tx_load_p, rx_pop_p}, 0);
      chk("R2", "char_bits", char_bits, 5);
      chk("R2", "fifo_deep", fifo_deep, 0);
      // R2: pointer starts at MR1 -> first mode write is MR1, second MR2
      wr(A_MODE, 8'h02);
      chk("R2", "first mode write reaches MR1", char_bits, 7);
      chk("R2", "MR0 untouched", fifo_deep, 0);
      wr(A_MODE, 8'h0F);
      chk("R2", "second mode write reaches MR2", stop_two, 1);

      // R3 R4 R5 R6: every command byte from both starting states
      ebrk = 0;
      for (int i = 0; i < 512; i++) begin
         int cb, code, low;
         cb = i % 256; code = cb >> 4; low = cb & 15;
         prx = (i < 256) ? 1 : 0;
         ptx = prx;
         wr(A_CMD, prx ? 8'h05 : 8'h0A);
         wr(A_CMD, cb);
         erx = (low & 2) ? 0 : (low & 1) ? 1 : prx;
         etx = (low & 8) ? 0 : (low & 4) ? 1 : ptx;
         if (code == 2) erx = 0;
         if (code == 3) etx = 0;
         if (code == 6) ebrk = 1;
         if (code == 7) ebrk = 0;
         chk("R3", $sformatf("rx_enable cmd %02h", cb), rx_enable, erx);
         chk("R3", $sformatf("tx_enable cmd %02h", cb), tx_enable, etx);
         chk("R4", $sformatf("reset pulses cmd %02h", cb), {rx_reset_p, tx_reset_p},
             {code == 2, code == 3});
         chk("R5", $sformatf("clear pulses cmd %02h", cb), {err_clear_p, brk_chg_clear_p},
             {code == 4, code == 5});
         chk("R6", $sformatf("break_on cmd %02h", cb), break_on, ebrk);
         @(negedge clk);
         chk("R4", "pulses last one cycle", {rx_reset_p, tx_reset_p, err_clear_p, brk_chg_clear_p}, 0);
      end

      // R8 R9: sweep MR1 format and MR2 stop
      for (int i = 0; i < 32; i++) begin
         int pe;
         wr(A_CMD, 8'h10);
         wr(A_MODE, i);
         wr(A_MODE, i % 16);
         pe = (((i >> 3) & 3) == 0) ? 1 : 0;
         chk("R8", $sformatf("char_bits mr1 %0h", i), char_bits, 5 + (i & 3));
         chk("R8", $sformatf("parity_en mr1 %0h", i), parity_en, pe);
         chk("R8", $sformatf("parity_odd mr1 %0h", i), parity_odd, pe & ((i >> 2) & 1));
         chk("R9", $sformatf("stop_two mr2 %0h", i % 16), stop_two, ((i % 16) >= 8) ? 1 : 0);
         // R7: pointer saturates at MR2
         wr(A_MODE, 8'h07);
         chk("R9", "value 7 is one stop bit", stop_two, 0);
         chk("R7", "saturated write left MR1 alone", char_bits, 5 + (i & 3));
      end

      // R10: MR0 fields
      for (int v = 0; v < 4; v++) begin
         wr(A_CMD, 8'hB0);
         wr(A_MODE, v << 3);
         chk("R10", "fifo_deep", fifo_deep, v & 1);
         chk("R10", "tx_half_level", tx_half_level, (v >> 1) & 1);
      end

      // R7: read-back through the pointer
      wr(A_CMD, 8'hB0); wr(A_MODE, 8'h18); wr(A_MODE, 8'h07); wr(A_MODE, 8'h0F);
      wr(A_CMD, 8'hB0);
      rd(A_MODE, d); chk("R7", "read MR0", d, 8'h18);
      rd(A_MODE, d); chk("R7", "read MR1", d, 8'h07);
      rd(A_MODE, d); chk("R7", "read MR2", d, 8'h0F);
      rd(A_MODE, d); chk("R7", "read saturates at MR2", d, 8'h0F);
      wr(A_CMD, 8'hB0); wr(A_CMD, 8'h40);
      rd(A_MODE, d); chk("R7", "code 4 leaves pointer", d, 8'h18);
      wr(A_CMD, 8'h10);
      rd(A_MODE, d); chk("R7", "code 1 points at MR1", d, 8'h07);

      // R11: status mapping, all patterns
      for (int s = 0; s < 256; s++) begin
         st_vec = 8'(s);
         rd(A_STAT, d);
         chk("R11", $sformatf("status %02h", s), d, s);
      end
      st_vec = 8'h00;
      wr(A_STAT, 8'h5C);
      chk("R11", "clk_sel load", clk_sel, 8'h5C);

      // R12: data offset
      wr(A_DATA, 8'hA7);
      chk("R12", "tx_load_p", tx_load_p, 1);
      chk("R12", "tx_byte", tx_byte, 8'hA7);
      @(negedge clk);
      chk("R12", "tx_load_p one cycle", tx_load_p, 0);
      rx_byte = 8'h3E;
      rd(A_DATA, d);
      chk("R12", "rx data", d, 8'h3E);
      chk("R12", "rx_pop_p", rx_pop_p, 1);
      @(negedge clk);
      chk("R12", "rx_pop_p one cycle", rx_pop_p, 0);

      // R1: address window sweep
      st_vec = 8'hA5;
      for (int a = 0; a < 16; a++) begin
         wr(A_CMD, 8'h0A);
         wr(A_STAT, 8'h00);
         wr(a, 8'h05);
         chk("R1", $sformatf("enable via addr %0d", a), rx_enable, (a == A_CMD) ? 1 : 0);
         wr(a, 8'hC3);
         chk("R1", $sformatf("clk_sel via addr %0d", a), clk_sel, (a == A_STAT) ? 8'hC3 : 0);
         chk("R1", $sformatf("tx_load via addr %0d", a), tx_load_p, (a == A_DATA) ? 1 : 0);
         if (a < 8 || a > 11) begin
            rd(a, d);
            chk("R1", $sformatf("read miss addr %0d", a), d, 0);
            chk("R1", $sformatf("no pop addr %0d", a), rx_pop_p, 0);
         end else if (a == A_STAT) begin
            rd(a, d);
            chk("R1", "status in window", d, 8'hA5);
         end
      end

      finish_run();
   end
endmodule